// File: doc/BRIEF.md
# Bit and Nibble Rotate Unit

This unit takes an operation code, an accumulator byte, a carry bit and a byte read from memory. It returns the accumulator, the memory byte and the carry after one rotate step. Four of the codes rotate the accumulator by one bit position. Two of those four pass the shifted-out bit through the carry, and the other two wrap it directly back into the word. Two further codes move whole 4-bit digits around a ring of three slots: the accumulator's low digit, the memory byte's high digit and the memory byte's low digit. The remaining codes pass every input through unchanged.

Each result comes with a write enable. The carry enable marks a bit rotate, which changes only the carry flag. The memory enable marks a digit rotate, which writes the memory byte back and leaves every flag alone. Results are registered by default, so they appear one clock after the inputs. A parameter selects a purely combinational variant instead. Fetching the memory byte and storing it back, including any wait states, is the job of the surrounding datapath.

Top module: `nib_bit_rotator`

## Requirements
- R1: While `rst_n` is low, every output is 0, including both write enables.
- R2: Op code 1, rotate right. The result has old bit 0 in bit 7, and each other bit k moves to position k-1. The new carry is old bit 0.
- R3: Op code 2, rotate left. The result has old bit 7 in bit 0, and each other bit k moves to position k+1. The new carry is old bit 7.
- R4: Op code 3, rotate right through carry. The result has the old carry in bit 7 and old bits 7..1 in bits 6..0. The new carry is old bit 0.
- R5: Op code 4, rotate left through carry. The result has the old carry in bit 0 and old bits 6..0 in bits 7..1. The new carry is old bit 7.
- R6: For op codes 1 to 4, `cy_we_o` is 1 and `mem_we_o` is 0, and `mem_o` equals `mem_i`. The two enables are never high together.
- R7: Op code 5, digit rotate right, makes three changes. The new accumulator bits 3..0 take memory bits 3..0. The new memory bits 7..4 take old accumulator bits 3..0. The new memory bits 3..0 take old memory bits 7..4.
- R8: Op code 6, digit rotate left, makes three changes. The new accumulator bits 3..0 take memory bits 7..4. The new memory bits 3..0 take old accumulator bits 3..0. The new memory bits 7..4 take old memory bits 3..0.
- R9: For op codes 5 and 6, accumulator bits 7..4 are unchanged, `mem_we_o` is 1, `cy_we_o` is 0 and `cy_o` equals `cy_i`. Three successive digit rotates in the same direction restore both bytes.
- R10: For op codes 0 and 7, `acc_o`, `mem_o` and `cy_o` equal their inputs, and both write enables are 0.
- R11: With the default registered variant, outputs change only on the rising clock edge after the inputs are applied, so the latency is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code (0 idle, 1-4 bit rotates, 5-6 digit rotates, 7 idle) |
| acc_i | input | 8 | Accumulator before the operation |
| cy_i | input | 1 | Carry flag before the operation |
| mem_i | input | 8 | Memory byte before the operation |
| acc_o | output | 8 | Accumulator after the operation |
| mem_o | output | 8 | Memory byte after the operation |
| mem_we_o | output | 1 | Memory byte is to be written back |
| cy_o | output | 1 | Carry after the operation |
| cy_we_o | output | 1 | Carry flag is to be updated |

## Verification
The checker compares each output with the inputs captured one edge earlier. It therefore assumes that the inputs are stable and known across each rising edge, and that the first edge after reset release carries a valid request. The bench changes inputs only on falling edges and holds them through the following rising edge. It keeps every input at a known value from time zero, so every captured request is well defined, including the idle codes.

// File: rtl/rot_pkg.sv
package rot_pkg;

   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      ROT_IDLE = 3'd0,
      ROT_RR   = 3'd1,
      ROT_RL   = 3'd2,
      ROT_RRC  = 3'd3,
      ROT_RLC  = 3'd4,
      ROT_DR   = 3'd5,
      ROT_DL   = 3'd6,
      ROT_RSVD = 3'd7
   } rot_op_e;

endpackage

// File: rtl/rot_bit_unit.sv
module rot_bit_unit
   import rot_pkg::*;
#(
   parameter int W = 8
) (
   input  rot_op_e        op,
   input  logic [W-1:0]   a,
   input  logic           cy,
   output logic [W-1:0]   res,
   output logic           cy_n,
   output logic           hit
);
   localparam int MSB = W - 1;

   logic          fill_r;
   logic          fill_l;
   logic [W-1:0]  rr;
   logic [W-1:0]  rl;

   assign fill_r = (op == ROT_RRC) ? cy : a[0];
   assign fill_l = (op == ROT_RLC) ? cy : a[MSB];

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == MSB) begin : g_top
         assign rr[i] = fill_r;
      end else begin : g_mid_r
         assign rr[i] = a[i+1];
      end
      if (i == 0) begin : g_bot
         assign rl[i] = fill_l;
      end else begin : g_mid_l
         assign rl[i] = a[i-1];
      end
   end

   always_comb begin
      res  = a;
      cy_n = cy;
      hit  = 1'b0;
      case (op)
         ROT_RR, ROT_RRC: begin
            res  = rr;
            cy_n = a[0];
            hit  = 1'b1;
         end
         ROT_RL, ROT_RLC: begin
            res  = rl;
            cy_n = a[MSB];
            hit  = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/rot_digit_unit.sv
module rot_digit_unit
   import rot_pkg::*;
#(
   parameter int W = 8
) (
   input  rot_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   m,
   output logic [W-1:0]   a_n,
   output logic [W-1:0]   m_n,
   output logic           hit
);
   localparam int H = W / 2;

   logic [H-1:0] a_hi, a_lo, m_hi, m_lo;

   assign a_hi = a[W-1:H];
   assign a_lo = a[H-1:0];
   assign m_hi = m[W-1:H];
   assign m_lo = m[H-1:0];

   always_comb begin
      a_n = a;
      m_n = m;
      hit = 1'b0;
      case (op)
         ROT_DR: begin
            a_n = {a_hi, m_lo};
            m_n = {a_lo, m_hi};
            hit = 1'b1;
         end
         ROT_DL: begin
            a_n = {a_hi, m_hi};
            m_n = {m_lo, a_lo};
            hit = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/rot_out_stage.sv
module rot_out_stage #(
   parameter int W       = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d_acc,
   input  logic [W-1:0]  d_mem,
   input  logic          d_mwe,
   input  logic          d_cy,
   input  logic          d_cwe,
   output logic [W-1:0]  q_acc,
   output logic [W-1:0]  q_mem,
   output logic          q_mwe,
   output logic          q_cy,
   output logic          q_cwe
);
   localparam int PW = 2 * W + 3;

   logic [PW-1:0] d_pack;
   logic [PW-1:0] q_pack;

   assign d_pack = {d_acc, d_mem, d_mwe, d_cy, d_cwe};
   assign {q_acc, q_mem, q_mwe, q_cy, q_cwe} = q_pack;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_pack <= '0;
         else        q_pack <= d_pack;
      end
   end else begin : g_comb
      assign q_pack = d_pack;
   end

endmodule

// File: rtl/nib_bit_rotator.sv
module nib_bit_rotator
   import rot_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic              cy_i,
   input  logic [DATA_W-1:0] mem_i,
   output logic [DATA_W-1:0] acc_o,
   output logic [DATA_W-1:0] mem_o,
   output logic              mem_we_o,
   output logic              cy_o,
   output logic              cy_we_o
);
   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("nib_bit_rotator: DATA_W must be even and at least 2");
   end

   rot_op_e             op_e;
   logic [DATA_W-1:0]   bit_res;
   logic                bit_cy;
   logic                bit_hit;
   logic [DATA_W-1:0]   dig_acc;
   logic [DATA_W-1:0]   dig_mem;
   logic                dig_hit;
   logic [DATA_W-1:0]   nx_acc;
   logic [DATA_W-1:0]   nx_mem;
   logic                nx_mwe;
   logic                nx_cy;
   logic                nx_cwe;

   assign op_e = rot_op_e'(op_i);

   rot_bit_unit #(.W(DATA_W)) u_bit (
      .op   (op_e),
      .a    (acc_i),
      .cy   (cy_i),
      .res  (bit_res),
      .cy_n (bit_cy),
      .hit  (bit_hit)
   );

   rot_digit_unit #(.W(DATA_W)) u_dig (
      .op  (op_e),
      .a   (acc_i),
      .m   (mem_i),
      .a_n (dig_acc),
      .m_n (dig_mem),
      .hit (dig_hit)
   );

   always_comb begin
      nx_acc = acc_i;
      nx_mem = mem_i;
      nx_mwe = 1'b0;
      nx_cy  = cy_i;
      nx_cwe = 1'b0;
      if (bit_hit) begin
         nx_acc = bit_res;
         nx_cy  = bit_cy;
         nx_cwe = 1'b1;
      end else if (dig_hit) begin
         nx_acc = dig_acc;
         nx_mem = dig_mem;
         nx_mwe = 1'b1;
      end
   end

   rot_out_stage #(.W(DATA_W), .REG_OUT(REG_OUT)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d_acc (nx_acc),
      .d_mem (nx_mem),
      .d_mwe (nx_mwe),
      .d_cy  (nx_cy),
      .d_cwe (nx_cwe),
      .q_acc (acc_o),
      .q_mem (mem_o),
      .q_mwe (mem_we_o),
      .q_cy  (cy_o),
      .q_cwe (cy_we_o)
   );

endmodule

// File: rtl/rot_check.sv
module rot_check
   import rot_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [OP_W-1:0]   op_i,
   input logic [DATA_W-1:0] acc_i,
   input logic              cy_i,
   input logic [DATA_W-1:0] mem_i,
   input logic [DATA_W-1:0] acc_o,
   input logic [DATA_W-1:0] mem_o,
   input logic              mem_we_o,
   input logic              cy_o,
   input logic              cy_we_o
);
   localparam int W = DATA_W;
   localparam int H = DATA_W / 2;

   logic [OP_W-1:0] p_op;
   logic [W-1:0]    p_acc;
   logic [W-1:0]    p_mem;
   logic            p_cy;
   logic            p_ok;

   if (REG_OUT) begin : g_cap_reg
      logic seen_rst = 1'b0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_ok  <= 1'b0;
            p_op  <= '0;
            p_acc <= '0;
            p_mem <= '0;
            p_cy  <= 1'b0;
         end else begin
            p_ok  <= 1'b1;
            p_op  <= op_i;
            p_acc <= acc_i;
            p_mem <= mem_i;
            p_cy  <= cy_i;
         end
      end

      always_ff @(posedge clk) seen_rst <= !rst_n;

      AST_RESET_CLEAR: assert property (@(posedge clk)
         (!rst_n && seen_rst) |-> (acc_o == '0 && mem_o == '0 && !mem_we_o && !cy_o && !cy_we_o)); // R1
   end else begin : g_cap_comb
      assign p_ok  = 1'b1;
      assign p_op  = op_i;
      assign p_acc = acc_i;
      assign p_mem = mem_i;
      assign p_cy  = cy_i;
   end

   AST_RR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (p_ok && p_op == ROT_RR) |-> (acc_o == {p_acc[0], p_acc[W-1:1]} && cy_o == p_acc[0])); // R2
   AST_RL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (p_ok && p_op == ROT_RL) |-> (acc_o == {p_acc[W-2:0], p_acc[W-1]} && cy_o == p_acc[W-1])); // R3
   AST_RRC_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (p_ok && p_op == ROT_RRC) |-> (acc_o == {p_cy, p_acc[W-1:1]} && cy_o == p_acc[0])); // R4
   AST_RLC_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (p_ok && p_op == ROT_RLC) |-> (acc_o == {p_acc[W-2:0], p_cy} && cy_o == p_acc[W-1])); // R5
   AST_BIT_CARRY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (p_ok && p_op inside {ROT_RR, ROT_RL, ROT_RRC, ROT_RLC}) |-> (cy_we_o && !mem_we_o && mem_o == p_mem)); // R6
   AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we_o && cy_we_o)); // R6
   AST_DR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (p_ok && p_op == ROT_DR) |-> (acc_o[H-1:0] == p_mem[H-1:0] && mem_o == {p_acc[H-1:0], p_mem[W-1:H]})); // R7
   AST_DL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (p_ok && p_op == ROT_DL) |-> (acc_o[H-1:0] == p_mem[W-1:H] && mem_o == {p_mem[H-1:0], p_acc[H-1:0]})); // R8
   AST_DIGIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (p_ok && (p_op == ROT_DR || p_op == ROT_DL)) |->
         (acc_o[W-1:H] == p_acc[W-1:H] && mem_we_o && !cy_we_o && cy_o == p_cy)); // R9
   AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (p_ok && (p_op == ROT_IDLE || p_op == ROT_RSVD)) |->
         (acc_o == p_acc && mem_o == p_mem && cy_o == p_cy && !mem_we_o && !cy_we_o)); // R10

endmodule

bind nib_bit_rotator rot_check #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_rot_check (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_i     (op_i),
   .acc_i    (acc_i),
   .cy_i     (cy_i),
   .mem_i    (mem_i),
   .acc_o    (acc_o),
   .mem_o    (mem_o),
   .mem_we_o (mem_we_o),
   .cy_o     (cy_o),
   .cy_we_o  (cy_we_o)
);

// File: tb/nib_bit_rotator_test.sv
`timescale 1ns/1ps
module nib_bit_rotator_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] op_i = 3'd0;
   logic [7:0] acc_i = 8'h00;
   logic       cy_i = 1'b0;
   logic [7:0] mem_i = 8'h00;
   logic [7:0] acc_o;
   logic [7:0] mem_o;
   logic       mem_we_o;
   logic       cy_o;
   logic       cy_we_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   nib_bit_rotator uut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .cy_i(cy_i), .mem_i(mem_i),
      .acc_o(acc_o), .mem_o(mem_o), .mem_we_o(mem_we_o), .cy_o(cy_o), .cy_we_o(cy_we_o)
   );

   // {op, acc, cy, mem, exp_acc, exp_mem, exp_mwe, exp_cy, exp_cwe}
   localparam int NV = 14;
   localparam logic [38:0] VECS [NV] = '{
      {3'd1, 8'h81, 1'b0, 8'h3C, 8'hC0, 8'h3C, 1'b0, 1'b1, 1'b1},
      {3'd1, 8'h02, 1'b1, 8'h55, 8'h01, 8'h55, 1'b0, 1'b0, 1'b1},
      {3'd2, 8'h81, 1'b0, 8'hAA, 8'h03, 8'hAA, 1'b0, 1'b1, 1'b1},
      {3'd2, 8'h40, 1'b1, 8'h00, 8'h80, 8'h00, 1'b0, 1'b0, 1'b1},
      {3'd3, 8'h01, 1'b0, 8'h12, 8'h00, 8'h12, 1'b0, 1'b1, 1'b1},
      {3'd3, 8'h10, 1'b1, 8'h12, 8'h88, 8'h12, 1'b0, 1'b0, 1'b1},
      {3'd4, 8'h80, 1'b0, 8'hFF, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b1},
      {3'd4, 8'h08, 1'b1, 8'hFF, 8'h11, 8'hFF, 1'b0, 1'b0, 1'b1},
      {3'd5, 8'hA7, 1'b1, 8'h5C, 8'hAC, 8'h75, 1'b1, 1'b1, 1'b0},
      {3'd6, 8'hA7, 1'b0, 8'h5C, 8'hA5, 8'hC7, 1'b1, 1'b0, 1'b0},
      {3'd5, 8'h30, 1'b0, 8'h9F, 8'h3F, 8'h09, 1'b1, 1'b0, 1'b0},
      {3'd6, 8'h3E, 1'b1, 8'h12, 8'h31, 8'h2E, 1'b1, 1'b1, 1'b0},
      {3'd0, 8'h5A, 1'b1, 8'hC3, 8'h5A, 8'hC3, 1'b0, 1'b1, 1'b0},
      {3'd7, 8'h00, 1'b0, 8'hFF, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0}
   };

   function automatic logic [18:0] outs();
      return {acc_o, mem_o, mem_we_o, cy_o, cy_we_o};
   endfunction

   function automatic string tag_of(input logic [2:0] op);
      case (op)
         3'd1: return "R2/R6";
         3'd2: return "R3/R6";
         3'd3: return "R4/R6";
         3'd4: return "R5/R6";
         3'd5: return "R7/R9";
         3'd6: return "R8/R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string tag, input logic [18:0] got, input logic [18:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic drive(input logic [2:0] op, input logic [7:0] a, input logic c, input logic [7:0] m);
      @(negedge clk);
      op_i = op; acc_i = a; cy_i = c; mem_i = m;
      @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [18:0] snap;
      logic [7:0]  ra;
      logic        rc;

      repeat (3) @(negedge clk);
      check("R1", outs(), 19'd0);  // reset state
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < NV; i++) begin
         drive(VECS[i][38:36], VECS[i][35:28], VECS[i][27], VECS[i][26:19]);
         check(tag_of(VECS[i][38:36]), outs(), VECS[i][18:0]);
      end

      // R11: output holds before the edge, updates right after it
      snap = outs();
      @(negedge clk);
      op_i = 3'd1; acc_i = 8'h01; cy_i = 1'b0; mem_i = 8'h00;
      #1;
      check("R11 hold", outs(), snap);
      @(posedge clk); #1;
      check("R11 update", outs(), {8'h80, 8'h00, 1'b0, 1'b1, 1'b1});

      // R9: three digit rotates right restore both bytes, high digit kept
      ra = 8'hB1;
      drive(3'd5, ra, 1'b1, 8'h23);
      check("R9 step1", outs(), {8'hB3, 8'h12, 1'b1, 1'b1, 1'b0});
      drive(3'd5, acc_o, cy_o, mem_o);
      check("R9 step2", outs(), {8'hB2, 8'h31, 1'b1, 1'b1, 1'b0});
      drive(3'd5, acc_o, cy_o, mem_o);
      check("R9 step3", outs(), {8'hB1, 8'h23, 1'b1, 1'b1, 1'b0});

      // R2/R3: rotate left then right restores every byte value
      for (int v = 0; v < 256; v++) begin
         drive(3'd2, v[7:0], 1'b0, 8'h00);
         ra = acc_o; rc = cy_o;
         drive(3'd1, ra, rc, 8'h00);
         check("R2/R3 sweep", {acc_o, cy_o, 10'd0}, {v[7:0], v[7], 10'd0});
      end

      // R1: asynchronous reset in mid-run clears outputs at once
      drive(3'd6, 8'hFF, 1'b1, 8'hFF);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 async", outs(), 19'd0);
      @(negedge clk);
      check("R1 held", outs(), 19'd0);
      rst_n = 1'b1;
      drive(3'd4, 8'h7F, 1'b1, 8'h00);
      check("R5 after reset", outs(), {8'hFF, 8'h00, 1'b0, 1'b0, 1'b1});

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule